// File: doc/BRIEF.md
# Protection Entry Configuration Bank

This block stores the configuration of a set of memory protection entries. Each entry holds an 8-bit configuration byte and an XLEN-wide address word. Software reaches the bank through one CSR-style port that selects either the configuration space or the address space by index. In configuration space, one CSR word carries XLEN/8 configuration bytes of adjacent entries. Writes unpack that word into the entries and reads pack it back.

Each entry can be frozen by a lock bit. A locked entry drops every write to its configuration and address. An entry also drops writes when the entry above it is locked and uses top-of-range matching, because that range takes its base from the lower entry's address. Once set, a lock stays set until reset.

The bank drives every entry's configuration and address onto flat output buses for downstream range-matching logic. It also drives a registered count of entries whose match mode is not off.

Top module: `prot_entry_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every configuration byte, address word, `csr_rdata` and `active_count` becomes zero.
- R2: Configuration byte layout: bit0 read, bit1 write, bit2 execute, bits 4:3 match mode (0 off, 1 top-of-range, 2 naturally aligned 4 bytes, 3 naturally aligned power of two), bit7 lock. Bits 6:5 are stored as zero whatever is written, so they read back as zero.
- R3: Configuration CSR n holds entry n*(XLEN/8)+i in bits 8i+7:8i. A write updates each of those entries and a read returns them in the same positions.
- R4: Address CSR k reads and writes the address word of entry k. Read data appears on `csr_rdata` after the clock edge that samples the read request and holds until the next read.
- R5: An entry whose lock bit is set ignores writes to both its configuration byte and its address word.
- R6: Entry k also ignores writes while entry k+1 has its lock bit set and match mode 1. A locked successor in any other mode does not block. The highest entry has no successor, so only its own lock blocks it.
- R7: Lock bits are cleared only by reset. After reset, previously locked entries accept writes again.
- R8: A configuration index whose entries all lie at or above the entry count, or an address index at or above the entry count, reads as zero. Writes to such indices change nothing.
- R9: When XLEN is 64, writes to odd-numbered configuration CSRs are ignored.
- R10: `active_count` equals the number of entries whose match mode is not 0. It follows a configuration change one clock edge after the edge that stores it.
- R11: `entry_cfg` bits 8k+7:8k and `entry_addr` bits XLEN*k+XLEN-1:XLEN*k show entry k's stored state at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_req | input | 1 | Access request strobe |
| csr_wr | input | 1 | 1 selects write, 0 selects read |
| csr_space | input | 1 | 0 selects configuration space, 1 selects address space |
| csr_idx | input | $clog2(NUM_ENTRIES)+1 | CSR index within the selected space |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Registered read data |
| entry_cfg | output | 8*NUM_ENTRIES | All configuration bytes, entry k at byte k |
| entry_addr | output | XLEN*NUM_ENTRIES | All address words, entry k at word k |
| active_count | output | $clog2(NUM_ENTRIES+1) | Count of entries whose match mode is not off |

## Verification
The bound checker watches, on every cycle, that a locked entry and an entry guarded by a locked top-of-range successor keep their state unchanged. It also watches that the reserved configuration bits stay zero, that reads outside the bank return zero, that reset clears all state, and that the active count never exceeds the entry count. Other behaviours show only through the bench's scenarios: the byte packing across CSR words, the distinction between a locked successor in top-of-range mode and in other modes, and the one-edge lag of the active count. Release of locks by reset and the dropped odd-index writes at XLEN 64 are likewise shown by scenarios.

// File: rtl/prot_bank_pkg.sv
package prot_bank_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam int          LOCK_BIT      = 7;
  localparam int          MODE_HI       = 4;
  localparam int          MODE_LO       = 3;
  localparam logic [7:0]  CFG_KEEP_MASK = 8'h9F;  // bits 6:5 reserved

  function automatic match_mode_e mode_of(input logic [1:0] f);
    return match_mode_e'(f);
  endfunction

endpackage

// File: rtl/prot_entry.sv
module prot_entry
  import prot_bank_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_wbyte,
  input  logic            addr_we,
  input  logic [XLEN-1:0] addr_wdata,
  input  logic            succ_guard,
  output logic [7:0]      cfg_q,
  output logic [XLEN-1:0] addr_q
);

  logic frozen;
  assign frozen = cfg_q[LOCK_BIT] | succ_guard;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cfg_we && !frozen)  cfg_q  <= cfg_wbyte & CFG_KEEP_MASK;
      if (addr_we && !frozen) addr_q <= addr_wdata;
    end
  end

endmodule

// File: rtl/prot_active_counter.sv
module prot_active_counter #(
  parameter int NUM_ENTRIES = 16,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2*NUM_ENTRIES-1:0] mode_flat,
  output logic [CNT_W-1:0]         count_q
);

  logic [CNT_W-1:0] tally;

  always_comb begin
    tally = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (mode_flat[2*k +: 2] != 2'd0) tally = tally + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= tally;
  end

endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux #(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES) + 1
) (
  input  logic                        sel_addr,
  input  logic [IDX_W-1:0]            idx,
  input  logic [8*NUM_ENTRIES-1:0]    cfg_flat,
  input  logic [XLEN*NUM_ENTRIES-1:0] addr_flat,
  output logic [XLEN-1:0]             word
);

  localparam int BPC = XLEN / 8;

  always_comb begin
    word = '0;
    if (!sel_addr) begin
      for (int i = 0; i < BPC; i++) begin
        if (int'(idx) * BPC + i < NUM_ENTRIES)
          word[8*i +: 8] = cfg_flat[8*(int'(idx) * BPC + i) +: 8];
      end
    end else if (int'(idx) < NUM_ENTRIES) begin
      word = addr_flat[XLEN*int'(idx) +: XLEN];
    end
  end

endmodule

// File: rtl/prot_entry_bank.sv
module prot_entry_bank
  import prot_bank_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES) + 1,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        csr_req,
  input  logic                        csr_wr,
  input  logic                        csr_space,
  input  logic [IDX_W-1:0]            csr_idx,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [8*NUM_ENTRIES-1:0]    entry_cfg,
  output logic [XLEN*NUM_ENTRIES-1:0] entry_addr,
  output logic [CNT_W-1:0]            active_count
);

  localparam int BPC = XLEN / 8;

  logic [7:0]      cfg_q  [NUM_ENTRIES];
  logic [XLEN-1:0] addr_q [NUM_ENTRIES];
  logic [2*NUM_ENTRIES-1:0] mode_flat;
  logic                     odd_block;
  logic                     wr_cfg;
  logic                     wr_addr;
  logic [XLEN-1:0]          rd_word;

  // On 64-bit configurations the odd configuration CSRs do not exist.
  assign odd_block = (XLEN == 64) && csr_idx[0];
  assign wr_cfg    = csr_req && csr_wr && !csr_space && !odd_block;
  assign wr_addr   = csr_req && csr_wr &&  csr_space;

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    logic guard;
    logic cfg_we;
    logic addr_we;

    if (k < NUM_ENTRIES - 1) begin : g_succ
      // Top-of-range successor takes its base from this entry.
      assign guard = cfg_q[k+1][LOCK_BIT] &&
                     (mode_of(cfg_q[k+1][MODE_HI:MODE_LO]) == MODE_TOR);
    end else begin : g_last
      assign guard = 1'b0;
    end

    assign cfg_we  = wr_cfg  && (int'(csr_idx) == k / BPC);
    assign addr_we = wr_addr && (int'(csr_idx) == k);

    prot_entry #(.XLEN(XLEN)) u_entry (
      .clk        (clk),
      .rst        (rst),
      .cfg_we     (cfg_we),
      .cfg_wbyte  (csr_wdata[8*(k % BPC) +: 8]),
      .addr_we    (addr_we),
      .addr_wdata (csr_wdata),
      .succ_guard (guard),
      .cfg_q      (cfg_q[k]),
      .addr_q     (addr_q[k])
    );

    assign entry_cfg[8*k +: 8]        = cfg_q[k];
    assign entry_addr[XLEN*k +: XLEN] = addr_q[k];
    assign mode_flat[2*k +: 2]        = cfg_q[k][MODE_HI:MODE_LO];
  end

  prot_active_counter #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .CNT_W       (CNT_W)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .mode_flat (mode_flat),
    .count_q   (active_count)
  );

  prot_read_mux #(
    .XLEN        (XLEN),
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
  ) u_rmux (
    .sel_addr  (csr_space),
    .idx       (csr_idx),
    .cfg_flat  (entry_cfg),
    .addr_flat (entry_addr),
    .word      (rd_word)
  );

  always_ff @(posedge clk) begin
    if (rst)                     csr_rdata <= '0;
    else if (csr_req && !csr_wr) csr_rdata <= rd_word;
  end

endmodule

// File: rtl/prot_entry_bank_chk.sv
module prot_entry_bank_chk #(
  parameter int XLEN        = 32,
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = $clog2(NUM_ENTRIES) + 1,
  parameter int CNT_W       = $clog2(NUM_ENTRIES + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        csr_req,
  input logic                        csr_wr,
  input logic                        csr_space,
  input logic [IDX_W-1:0]            csr_idx,
  input logic [XLEN-1:0]             csr_rdata,
  input logic [8*NUM_ENTRIES-1:0]    entry_cfg,
  input logic [XLEN*NUM_ENTRIES-1:0] entry_addr,
  input logic [CNT_W-1:0]            active_count
);

  localparam int BPC      = XLEN / 8;
  localparam int CFG_CSRS = (NUM_ENTRIES + BPC - 1) / BPC;

  AST_RESET_CLEARS: assert property (@(posedge clk)  // R1
    rst |=> (entry_cfg == '0 && entry_addr == '0 && csr_rdata == '0 && active_count == '0));

  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)  // R8
    (csr_req && !csr_wr && ((csr_space && int'(csr_idx) >= NUM_ENTRIES) ||
                            (!csr_space && int'(csr_idx) >= CFG_CSRS)))
    |=> csr_rdata == '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)  // R10
    int'(active_count) <= NUM_ENTRIES);

  if (XLEN == 64) begin : g_odd
    AST_ODD_CFG_IGNORED: assert property (@(posedge clk) disable iff (rst)  // R9
      (csr_req && csr_wr && !csr_space && csr_idx[0]) |=> $stable(entry_cfg));
  end

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_chk
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)  // R5
      entry_cfg[8*k+7] |=> ($stable(entry_cfg[8*k +: 8]) && $stable(entry_addr[XLEN*k +: XLEN])));

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)  // R2
      entry_cfg[8*k+6 -: 2] == 2'b00);

    if (k < NUM_ENTRIES - 1) begin : g_tor
      AST_TOR_GUARD: assert property (@(posedge clk) disable iff (rst)  // R6
        (entry_cfg[8*(k+1)+7] && entry_cfg[8*(k+1)+4 -: 2] == 2'd1)
        |=> ($stable(entry_cfg[8*k +: 8]) && $stable(entry_addr[XLEN*k +: XLEN])));
    end
  end

endmodule

bind prot_entry_bank prot_entry_bank_chk #(
  .XLEN        (XLEN),
  .NUM_ENTRIES (NUM_ENTRIES),
  .IDX_W       (IDX_W),
  .CNT_W       (CNT_W)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .csr_req      (csr_req),
  .csr_wr       (csr_wr),
  .csr_space    (csr_space),
  .csr_idx      (csr_idx),
  .csr_rdata    (csr_rdata),
  .entry_cfg    (entry_cfg),
  .entry_addr   (entry_addr),
  .active_count (active_count)
);

// File: tb/prot_entry_bank_test.sv
`timescale 1ns/1ps
module prot_entry_bank_test;

  localparam int XLEN = 32;
  localparam int N    = 16;
  localparam int IW   = 5;
  localparam int CW   = 5;
  localparam int NV   = 34;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic            csr_req = 1'b0, csr_wr = 1'b0, csr_space = 1'b0;
  logic [IW-1:0]   csr_idx = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic [8*N-1:0]  entry_cfg;
  logic [XLEN*N-1:0] entry_addr;
  logic [CW-1:0]   active_count;

  prot_entry_bank #(.XLEN(XLEN), .NUM_ENTRIES(N)) uut (
    .clk(clk), .rst(rst), .csr_req(csr_req), .csr_wr(csr_wr),
    .csr_space(csr_space), .csr_idx(csr_idx), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .entry_cfg(entry_cfg), .entry_addr(entry_addr),
    .active_count(active_count)
  );

  // 64-bit variant for the odd configuration CSR rule
  logic         b_req = 1'b0, b_wr = 1'b0, b_space = 1'b0;
  logic [IW-1:0] b_idx = '0;
  logic [63:0]  b_wdata = '0;
  logic [63:0]  b_rdata;
  logic [8*N-1:0] b_cfg;
  logic [64*N-1:0] b_addr;
  logic [CW-1:0] b_count;

  prot_entry_bank #(.XLEN(64), .NUM_ENTRIES(N)) uut64 (
    .clk(clk), .rst(rst), .csr_req(b_req), .csr_wr(b_wr),
    .csr_space(b_space), .csr_idx(b_idx), .csr_wdata(b_wdata),
    .csr_rdata(b_rdata), .entry_cfg(b_cfg), .entry_addr(b_addr),
    .active_count(b_count)
  );

  // {read, space(1=addr), idx[4:0], wdata[31:0], expected[31:0], req[3:0]}
  localparam logic [74:0] VEC [NV] = '{
    {1'b0,1'b0,5'd0, 32'h1F0F0B01,32'h0,       4'd3},  // R3 write four bytes
    {1'b1,1'b0,5'd0, 32'h0,       32'h1F0F0B01,4'd3},  // R3
    {1'b0,1'b1,5'd5, 32'hDEADBEEF,32'h0,       4'd4},  // R4
    {1'b1,1'b1,5'd5, 32'h0,       32'hDEADBEEF,4'd4},  // R4
    {1'b0,1'b0,5'd1, 32'hFFE06013,32'h0,       4'd2},  // R2 reserved bits set
    {1'b1,1'b0,5'd1, 32'h0,       32'h9F800013,4'd2},  // R2
    {1'b0,1'b0,5'd1, 32'h00000000,32'h0,       4'd5},  // R5 entries 6,7 locked
    {1'b1,1'b0,5'd1, 32'h0,       32'h9F800000,4'd5},  // R5
    {1'b0,1'b1,5'd6, 32'h00001234,32'h0,       4'd5},  // R5
    {1'b1,1'b1,5'd6, 32'h0,       32'h0,       4'd5},  // R5
    {1'b0,1'b1,5'd5, 32'h00000055,32'h0,       4'd6},  // R6 successor locked, mode off
    {1'b1,1'b1,5'd5, 32'h0,       32'h00000055,4'd6},  // R6
    {1'b0,1'b0,5'd2, 32'h00008800,32'h0,       4'd6},  // R6 entry 9 locked TOR
    {1'b1,1'b0,5'd2, 32'h0,       32'h00008800,4'd6},  // R6
    {1'b0,1'b1,5'd8, 32'h00000055,32'h0,       4'd6},  // R6
    {1'b1,1'b1,5'd8, 32'h0,       32'h0,       4'd6},  // R6
    {1'b0,1'b0,5'd2, 32'h0013FF03,32'h0,       4'd6},  // R6 only entries 10,11 move
    {1'b1,1'b0,5'd2, 32'h0,       32'h00138800,4'd6},  // R6
    {1'b0,1'b1,5'd9, 32'h00000077,32'h0,       4'd5},  // R5
    {1'b1,1'b1,5'd9, 32'h0,       32'h0,       4'd5},  // R5
    {1'b0,1'b1,5'd10,32'hCAFE0000,32'h0,       4'd4},  // R4
    {1'b1,1'b1,5'd10,32'h0,       32'hCAFE0000,4'd4},  // R4
    {1'b0,1'b0,5'd3, 32'h88000000,32'h0,       4'd6},  // R6 highest entry locked TOR
    {1'b1,1'b0,5'd3, 32'h0,       32'h88000000,4'd6},  // R6
    {1'b0,1'b1,5'd14,32'h000000AB,32'h0,       4'd6},  // R6
    {1'b1,1'b1,5'd14,32'h0,       32'h0,       4'd6},  // R6
    {1'b0,1'b1,5'd15,32'h000000CD,32'h0,       4'd5},  // R5
    {1'b1,1'b1,5'd15,32'h0,       32'h0,       4'd5},  // R5
    {1'b0,1'b0,5'd4, 32'hFFFFFFFF,32'h0,       4'd8},  // R8
    {1'b1,1'b0,5'd4, 32'h0,       32'h0,       4'd8},  // R8
    {1'b0,1'b1,5'd16,32'h11111111,32'h0,       4'd8},  // R8
    {1'b1,1'b1,5'd16,32'h0,       32'h0,       4'd8},  // R8
    {1'b1,1'b1,5'd31,32'h0,       32'h0,       4'd8},  // R8
    {1'b1,1'b0,5'd0, 32'h0,       32'h1F0F0B01,4'd8}   // R8 no aliasing
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [74:0]     cur;
  logic [XLEN-1:0] got;

  task automatic check(input int req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic op(input logic rd, input logic sp, input logic [IW-1:0] idx,
                    input logic [XLEN-1:0] wd, output logic [XLEN-1:0] rdv);
    @(negedge clk);
    csr_req = 1'b1; csr_wr = !rd; csr_space = sp; csr_idx = idx; csr_wdata = wd;
    @(negedge clk);
    csr_req = 1'b0; csr_wr = 1'b0;
    rdv = csr_rdata;
  endtask

  task automatic op64(input logic rd, input logic [IW-1:0] idx,
                      input logic [63:0] wd, output logic [63:0] rdv);
    @(negedge clk);
    b_req = 1'b1; b_wr = !rd; b_space = 1'b0; b_idx = idx; b_wdata = wd;
    @(negedge clk);
    b_req = 1'b0; b_wr = 1'b0;
    rdv = b_rdata;
  endtask

  initial begin
    logic [63:0] r64;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, "cfg after reset",   64'(entry_cfg == '0),  64'd1);
    check(1, "addr after reset",  64'(entry_addr == '0), 64'd1);
    check(1, "rdata after reset", 64'(csr_rdata),        64'd0);
    check(1, "count after reset", 64'(active_count),     64'd0);

    for (int v = 0; v < NV; v++) begin
      cur = VEC[v];
      op(cur[74], cur[73], cur[72:68], cur[67:36], got);
      if (cur[74]) check(int'(cur[3:0]), $sformatf("vector %0d", v), 64'(got), 64'(cur[35:4]));
    end

    // R10 active entries: 1,2,3,7,9,10,15
    check(10, "active count", 64'(active_count), 64'd7);
    // R11 flat outputs
    check(11, "entry 7 cfg bus",   64'(entry_cfg[8*7 +: 8]),      64'h9F);
    check(11, "entry 10 addr bus", 64'(entry_addr[32*10 +: 32]), 64'hCAFE0000);
    check(11, "entry 5 addr bus",  64'(entry_addr[32*5 +: 32]),  64'h55);

    // R10 one-edge lag: entry 0 to TOR
    op(1'b0, 1'b0, 5'd0, 32'h1F0F0B08, got);
    check(10, "count before lag edge", 64'(active_count), 64'd7);
    @(negedge clk);
    check(10, "count after lag edge", 64'(active_count), 64'd8);

    // R7 reset releases locks
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check(7, "cfg cleared by reset",   64'(entry_cfg == '0), 64'd1);
    check(1, "count cleared by reset", 64'(active_count),    64'd0);
    op(1'b0, 1'b1, 5'd6, 32'h00000066, got);
    op(1'b1, 1'b1, 5'd6, 32'h0, got);
    check(7, "formerly locked addr writable", 64'(got), 64'h66);

    // R9 odd configuration CSR at XLEN 64
    op64(1'b0, 5'd1, 64'h0101010101010101, r64);
    check(9, "odd cfg write leaves bus", 64'(b_cfg == '0), 64'd1);
    op64(1'b1, 5'd1, 64'h0, r64);
    check(9, "odd cfg read", r64, 64'h0);
    op64(1'b0, 5'd0, 64'h0000000000000008, r64);
    check(9, "even cfg write", 64'(b_cfg[7:0]), 64'h08);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule